// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that is reached through a small 32-bit register bus. Software sets a division ratio that turns a slow reference strobe into coarse ticks. It also sets a reload count and then turns counting on. A down-counter loses one step per tick. If software does not restart it in time, the block raises a reset request to the system reset controller for one clock. It also sets a sticky flag that records the watchdog as the cause of the reset.

The reference strobe `ref_tick` is a one-cycle enable pulse in the block's own clock domain, for example 1 MHz. A division ratio of 1000 then gives one tick per millisecond, and a timeout of t seconds is programmed as a reload of t*1000.

To start the timer, software writes the divider, then the reload value, then a restart, and finally sets the enable bit. To stop it, software writes a restart and then clears the enable bit.

Top module: `wdt_prescaled`

## Requirements
- R1: After a synchronous reset, every register reads zero, `wdt_rst_req` is low and `bus_rdata` is zero.
- R2: A read returns its data on `bus_rdata` in the cycle after the read request. The control word sits at address 0x20, with bit 7 as the enable and bits 31:16 as the divider. A read of it returns those fields as last written and zero in all other bits. A read of address 0x00 returns zero, bit 9 included.
- R3: The reload register at address 0x24 keeps bits 15:0 of a write. Its upper bits are ignored and read back as zero.
- R4: While enabled, the prescaler emits one tick for every D reference strobes, where D is the divider. A divider of 0 or 1 gives one tick per strobe.
- R5: With a reload of N ≥ 1, the N-th tick after a restart makes `wdt_rst_req` high for exactly the one cycle after the clock edge that sampled the final strobe.
- R6: An expiry sets bit 1 of address 0x38. The bit stays set until software writes 1 to bit 1. Writing 0 to that bit leaves it unchanged.
- R7: After an expiry the counter reloads itself and counts toward a further expiry.
- R8: A write to address 0x00 with bit 9 set reloads the counter and clears the prescaler, so a full D*N strobes are needed again. A write to 0x00 with bit 9 clear changes nothing.
- R9: While the enable bit is clear, the prescaler and the counter hold their values and no reset request is raised. Counting resumes from the held state when the timer is enabled again.
- R10: A restart write takes priority over a tick that arrives in the same cycle, so that tick neither counts nor causes an expiry.
- R11: A reload value of zero expires on the first tick after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference strobe |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A read issued at a falling edge is sampled at the next clock edge. Its data is therefore checked one full cycle later, at the following falling edge. A reset request caused by a strobe driven before edge c is due in the cycle that follows edge c. The driver therefore pushes that cycle number into the scoreboard queue when it drives the strobe. The monitor compares `wdt_rst_req` against the head of the queue at every falling edge. It flags a pulse that arrives where none was queued, and it flags a queued cycle that passes with no pulse. This makes early, late, missing and extra expiries all visible, including the runs where a restart or a cleared enable should suppress the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_W      = 32;
  localparam logic [7:0] OFS_STAT  = 8'h00;
  localparam logic [7:0] OFS_CTRL  = 8'h20;
  localparam logic [7:0] OFS_LOAD  = 8'h24;
  localparam logic [7:0] OFS_CAUSE = 8'h38;
  localparam int BIT_RESTART = 9;
  localparam int BIT_ENABLE  = 7;
  localparam int BIT_CAUSE   = 1;
  localparam int DIV_LSB     = 16;
  localparam int DIV_W       = BUS_W - DIV_LSB;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              expire_i,
  output logic              enable_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              restart_o,
  output logic              cause_o
);
  localparam int PAD_W = BUS_W - CNT_W;

  logic wr_hit, rd_hit;
  logic [ADDR_W-1:0] a_stat, a_ctrl, a_load, a_cause;

  assign a_stat  = ADDR_W'(OFS_STAT);
  assign a_ctrl  = ADDR_W'(OFS_CTRL);
  assign a_load  = ADDR_W'(OFS_LOAD);
  assign a_cause = ADDR_W'(OFS_CAUSE);

  assign wr_hit = bus_en && bus_we;
  assign rd_hit = bus_en && !bus_we;
  assign restart_o = wr_hit && (bus_addr == a_stat) && bus_wdata[BIT_RESTART];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_o <= 1'b0;
      div_o    <= '0;
      load_o   <= '0;
    end else if (wr_hit) begin
      if (bus_addr == a_ctrl) begin
        enable_o <= bus_wdata[BIT_ENABLE];
        div_o    <= bus_wdata[BUS_W-1:DIV_LSB];
      end
      if (bus_addr == a_load)
        load_o <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cause_o <= 1'b0;
    else if (expire_i)
      cause_o <= 1'b1;
    else if (wr_hit && (bus_addr == a_cause) && bus_wdata[BIT_CAUSE])
      cause_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (rd_hit) begin
        if (bus_addr == a_ctrl) begin
          bus_rdata[BUS_W-1:DIV_LSB] <= div_o;
          bus_rdata[BIT_ENABLE]      <= enable_o;
        end else if (bus_addr == a_load) begin
          bus_rdata <= {{PAD_W{1'b0}}, load_o};
        end else if (bus_addr == a_cause) begin
          bus_rdata[BIT_CAUSE] <= cause_o;
        end
      end
    end
  end

  assert_stat_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && bus_addr == a_stat) |=> (bus_rdata == '0));
  assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (cause_o && !(wr_hit && bus_addr == a_cause)) |=> cause_o);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt;
  logic             at_end;

  assign at_end = (div <= DIV_W'(1)) || (pcnt >= div - DIV_W'(1));
  assign tick   = en && ref_tick && at_end && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)
      pcnt <= '0;
    else if (en && ref_tick)
      pcnt <= at_end ? '0 : pcnt + DIV_W'(1);
  end

  assert_pre_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(pcnt));
  assert_pre_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pcnt == '0));
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] load,
  output logic             expire_q
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (restart) begin
        cnt <= load;
      end else if (en && tick) begin
        if (cnt <= CNT_W'(1)) begin
          cnt      <= load;
          expire_q <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  assert_restart_loads_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == $past(load) && !expire_q));
  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> ($stable(cnt) && !expire_q));
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);
  logic             enable, restart, tick, cause;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] load;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire_i(wdt_rst_req), .enable_o(enable), .div_o(div),
    .load_o(load), .restart_o(restart), .cause_o(cause)
  );

  wdt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .en(enable), .clr(restart),
    .ref_tick(ref_tick), .div(div), .tick(tick)
  );

  wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(enable), .restart(restart),
    .tick(tick), .load(load), .expire_q(wdt_rst_req)
  );

  assert_cause_set_R6: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |=> cause);
  assert_req_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> $past(enable));
endmodule

// File: tb/sim_wdt_prescaled.sv
module sim_wdt_prescaled;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int checks = 0, errors = 0, cyc = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_prescaled u0 (.clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req));

  // monitor: scoreboard of expected reset-request cycles
  always @(negedge clk) begin
    if (!rst) begin
      if (wdt_rst_req) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end else begin
          errors++;
          $display("FAIL %s unexpected reset request at cycle %0d, expected %0d",
                   (tag_q.size() > 0) ? tag_q[0] : "R9/R10", cyc,
                   (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        checks++; errors++;
        $display("FAIL %s missing reset request at cycle %0d, actual 0 expected 1",
                 tag_q[0], cyc);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit with_ref = 0);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; ref_tick = with_ref;
    @(negedge clk);
    bus_en = 0; bus_we = 0; ref_tick = 0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h actual 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
    end
  endtask

  // one reference strobe followed by one idle cycle
  task automatic pulse(input bit expect_req, input string tag);
    @(negedge clk);
    ref_tick = 1;
    if (expect_req) begin exp_q.push_back(cyc + 1); tag_q.push_back(tag); end
    @(negedge clk);
    ref_tick = 0;
  endtask

  task automatic pulses(input int n, input bit last_expires, input string tag);
    for (int i = 1; i <= n; i++) pulse(last_expires && (i == n), tag);
  endtask

  task automatic start(input int div, input int load);
    wr(8'h20, div << 16);
    wr(8'h24, load);
    wr(8'h00, 32'h200);
    wr(8'h20, (div << 16) | 32'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: bench did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    checks++;
    if (wdt_rst_req !== 0 || bus_rdata !== 0) begin
      errors++; $display("FAIL R1 outputs after reset actual %b/%h expected 0/0", wdt_rst_req, bus_rdata);
    end
    rd_check(8'h20, 0, "R1"); rd_check(8'h24, 0, "R1"); rd_check(8'h38, 0, "R1");

    // register readback
    wr(8'h20, 32'hABCD_FF7F);
    rd_check(8'h20, 32'hABCD_0000, "R2");
    wr(8'h20, 32'h0004_0080);
    rd_check(8'h20, 32'h0004_0080, "R2");
    wr(8'h20, 0);
    wr(8'h24, 32'h1234_5678);
    rd_check(8'h24, 32'h0000_5678, "R3");
    rd_check(8'h00, 0, "R2");

    // basic expiry: divider 4, reload 3 -> 12 strobes
    start(4, 3);
    pulses(12, 1, "R4 R5");
    rd_check(8'h38, 32'h2, "R6");
    pulses(12, 1, "R7");
    wr(8'h38, 0);
    rd_check(8'h38, 32'h2, "R6");
    wr(8'h38, 32'h2);
    rd_check(8'h38, 0, "R6");

    // restart mid-prescale needs a full period again
    wr(8'h00, 32'h200);
    pulses(6, 0, "R8");
    wr(8'h00, 32'h200);
    pulses(12, 1, "R8");
    // status write without restart bit changes nothing
    pulses(6, 0, "R8");
    wr(8'h00, 32'h0000_01FF);
    pulses(6, 1, "R8");

    // disable holds prescaler and counter
    wr(8'h00, 32'h200);
    pulses(5, 0, "R9");
    wr(8'h20, 32'h0004_0000);
    pulses(30, 0, "R9");
    wr(8'h20, 32'h0004_0080);
    pulses(7, 1, "R9");

    // restart in the same cycle as the final strobe wins
    wr(8'h00, 32'h200);
    pulses(11, 0, "R10");
    wr(8'h00, 32'h200, 1);
    pulses(12, 1, "R10");

    // divider 1: every strobe is a tick
    start(1, 5);
    pulses(5, 1, "R4");

    // zero reload expires on first tick
    start(4, 0);
    pulses(3, 0, "R11");
    pulse(1, "R11");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R5 pending expiries actual %0d expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule